// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a small synchronous burst SRAM. Reads and writes can follow each other on every clock with no idle cycle between them. Address and control are registered on the rising edge. Read data is driven in the cycle that follows the edge that registered its address, which is the flow-through behaviour. Write data arrives one cycle after its address. A short pipeline therefore holds the pending write's address and byte mask until that data is sampled.

A controller starts an operation with a load cycle. It then either loads a new address on each clock or advances a two-bit burst counter that wraps inside an aligned group of four words. The counter can step in linear or in interleaved order. A clock enable freezes every register. Three synchronous chip selects and a sleep input turn a cycle into an idle cycle. An asynchronous output enable gates the data drivers. The data bus appears as separate input, output and drive-enable ports.

Top module: `zbt_ft_sram`

## Requirements
- R1: A load cycle (`adv_ld`=0) starts an operation only when `sel1_n`=0, `sel2`=1, `sel3_n`=0 and `sleep`=0. `wr_n`=1 selects a read and `wr_n`=0 selects a write. Any other load cycle is idle, and `dout_oe` stays 0 in the cycle that follows it.
- R2: While `clk_en_n`=1 the edge is ignored. The registered operation, the address, the pending write and the output data stay unchanged.
- R3: For a read registered at edge k, `dout` carries the word at that address during the cycle after edge k, and `dout_oe`=1 if `oe_n`=0.
- R4: Reads and writes may alternate on every enabled clock, with no wait or idle cycle inserted.
- R5: A write samples `din` at the next enabled edge after its address edge. Lane i covers bits [9i+8:9i] and is updated only if `lane_en_n[i]`=0 at the address edge.
- R6: A read registered at the same edge that completes a write to the same address returns the new data in the written lanes and the old contents in the others.
- R7: `oe_n`=1 drives `dout_oe` to 0 at once, without a clock edge.
- R8: `dout_oe` is 0 in the data cycle of every write, whatever the value of `oe_n`.
- R9: With `burst_ileave`=0, each advance cycle takes word bits [1:0] to (b+n) mod 4. Here b is the loaded address bits [1:0], n is the advance count, and the upper bits stay at their loaded value.
- R10: With `burst_ileave`=1, each advance cycle takes word bits [1:0] to b XOR n.
- R11: With `sleep`=1 at an enabled edge, the next cycle is idle with `dout_oe`=0. An advance cycle that follows an idle cycle stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| wr_n | input | 1 | 0 selects a write on a load cycle |
| lane_en_n | input | LANES | Per-lane write enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| burst_ileave | input | 1 | 1 selects interleaved order, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power idle request, active high |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_oe | output | 1 | Drive enable for `dout` |

## Verification
The bench builds the block with a 5-bit address, giving 32 words, and four 9-bit lanes. With so few words, random addresses land on the pending write very often, so the same-edge read-after-write merge of R6 and partial lane masks come up many times. The full four-lane width covers masks with mixed lanes. The small array also lets a first pass fill every word with linear bursts, so no read ever returns an unwritten word.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low word bits for burst step n from base b
  function automatic logic [1:0] burst_lsb(input logic [1:0] b,
                                           input logic [1:0] n,
                                           input logic       il);
    return il ? (b ^ n) : (b + n);
  endfunction
endpackage

// File: rtl/zbt_burst_ctrl.sv
module zbt_burst_ctrl
  import zbt_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             sel_ok,
  input  logic             sleep,
  input  logic             wr_n,
  input  logic             adv_ld,
  input  logic             ileave,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_en_n,
  output op_e              op_q,
  output logic [AW-1:0]    addr_q,
  output logic [AW-1:0]    nxt_addr,
  output logic [LANES-1:0] be_q
);
  logic [AW-1:0] base_q, nbase;
  logic [1:0]    cnt_q, ncnt;
  op_e           nop;

  always_comb begin
    if (!adv_ld) begin
      nop   = sel_ok ? (wr_n ? OP_RD : OP_WR) : OP_IDLE;
      nbase = addr;
      ncnt  = 2'd0;
    end else begin
      nop   = sleep ? OP_IDLE : op_q;
      nbase = base_q;
      ncnt  = cnt_q + 2'd1;
    end
    nxt_addr = {nbase[AW-1:2], burst_lsb(nbase[1:0], ncnt, ileave)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      be_q   <= '0;
    end else if (ce) begin
      op_q   <= nop;
      base_q <= nbase;
      cnt_q  <= ncnt;
      addr_q <= nxt_addr;
      be_q   <= ~lane_en_n;
    end
  end

  // R1: a selected load cycle starts the requested operation
  a_r1_select: assert property (@(posedge clk) disable iff (rst)
    (ce && !adv_ld && sel_ok) |=> (op_q == ($past(wr_n) ? OP_RD : OP_WR)));

  // R1: an unselected load cycle is idle
  a_r1_deselect: assert property (@(posedge clk) disable iff (rst)
    (ce && !adv_ld && !sel_ok) |=> (op_q == OP_IDLE));

  // R2: a disabled edge holds the registered state
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(op_q) && $stable(addr_q) && $stable(be_q)));

  // R9/R10: an advance never leaves the aligned group of four
  a_r9_group_wrap: assert property (@(posedge clk) disable iff (rst)
    (ce && adv_ld) |=> (addr_q[AW-1:2] == $past(addr_q[AW-1:2])));

  // R11: sleep forces the next cycle idle
  a_r11_sleep: assert property (@(posedge clk) disable iff (rst)
    (ce && sleep) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/zbt_lane_ram.sv
module zbt_lane_ram #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    ce,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    logic [LANE_W-1:0] rd_l;

    always_ff @(posedge clk) begin
      if (ce && we && wbe[g]) ram[waddr] <= wdata[g*LANE_W +: LANE_W];
      if (ce) rd_l <= ram[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_l;
  end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    adv_ld,
  input  logic                    burst_ileave,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_oe
);
  localparam int DW = LANES * LANE_W;

  logic              ce, sel_ok;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [LANES-1:0]  be_q, byp_q;
  logic [DW-1:0]     ram_q, byp_d;

  assign ce     = !clk_en_n;
  assign sel_ok = !sel1_n && sel2 && !sel3_n && !sleep;

  zbt_burst_ctrl #(.AW(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .sel_ok(sel_ok), .sleep(sleep),
    .wr_n(wr_n), .adv_ld(adv_ld), .ileave(burst_ileave), .addr(addr),
    .lane_en_n(lane_en_n), .op_q(op_q), .addr_q(addr_q),
    .nxt_addr(nxt_addr), .be_q(be_q)
  );

  zbt_lane_ram #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk(clk), .ce(ce), .we(op_q == OP_WR), .waddr(addr_q), .wbe(be_q),
    .wdata(din), .raddr(nxt_addr), .rdata(ram_q)
  );

  // pending write landing on the same edge as a read of its address
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= '0;
      byp_d <= '0;
    end else if (ce) begin
      byp_q <= (op_q == OP_WR && addr_q == nxt_addr) ? be_q : '0;
      byp_d <= din;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign dout[g*LANE_W +: LANE_W] = byp_q[g] ? byp_d[g*LANE_W +: LANE_W]
                                               : ram_q[g*LANE_W +: LANE_W];
  end

  assign dout_oe = (op_q == OP_RD) && !oe_n;

  // R8: the data cycle of a write never drives the bus
  a_r8_write_hiz: assert property (@(posedge clk) disable iff (rst)
    (ce && !adv_ld && sel_ok && !wr_n) |=> !dout_oe);

  // R3: a selected read load drives data next cycle when enabled
  a_r3_read_drive: assert property (@(posedge clk) disable iff (rst)
    (ce && !adv_ld && sel_ok && wr_n) |=> (dout_oe == !oe_n));
endmodule

// File: tb/zbt_ft_sram_test.sv
module zbt_ft_sram_test;
  localparam int AW = 5, LANES = 4, LW = 9, DW = 36, DEPTH = 32;

  logic clk = 0, rst = 1, clk_en_n = 0, sel1_n = 0, sel2 = 1, sel3_n = 0;
  logic wr_n = 1, adv_ld = 0, burst_ileave = 0, oe_n = 0, sleep = 0;
  logic [LANES-1:0] lane_en_n = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] mm [DEPTH];
  int m_op;
  logic [AW-1:0] m_base, m_addr;
  logic [1:0] m_cnt;
  logic [LANES-1:0] m_be;

  zbt_ft_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) uut (.*);

  always #5 clk = ~clk;

  task automatic model_edge();
    if (rst) begin
      m_op = 0; m_base = '0; m_cnt = 0; m_addr = '0; m_be = '0;
    end else if (!clk_en_n) begin
      if (m_op == 2)
        for (int i = 0; i < LANES; i++)
          if (m_be[i]) mm[m_addr][i*LW +: LW] = din[i*LW +: LW];
      if (!adv_ld) begin
        m_op = (!sel1_n && sel2 && !sel3_n && !sleep) ? (wr_n ? 1 : 2) : 0;
        m_base = addr; m_cnt = 0;
      end else begin
        if (sleep) m_op = 0;
        m_cnt = m_cnt + 2'd1;
      end
      m_addr = {m_base[AW-1:2], burst_ileave ? (m_base[1:0] ^ m_cnt)
                                             : (m_base[1:0] + m_cnt)};
      m_be = ~lane_en_n;
    end
  endtask

  task automatic check(input string tag);
    logic exp_oe;
    exp_oe = (m_op == 1) && !oe_n;
    checks++;
    if (dout_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s dout_oe actual=%b expected=%b", tag, dout_oe, exp_oe);
    end
    if (exp_oe) begin
      checks++;
      if (dout !== mm[m_addr]) begin
        errors++;
        $display("FAIL %s dout actual=%h expected=%h", tag, dout, mm[m_addr]);
      end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic drive(input bit adv, input bit wr, input int a,
                       input logic [LANES-1:0] mask_n, input string tag);
    clk_en_n = 0; sel1_n = 0; sel2 = 1; sel3_n = 0; sleep = 0;
    adv_ld = adv; wr_n = !wr; addr = AW'(a); lane_en_n = mask_n;
    din = {4'($urandom), $urandom};
    step(tag);
  endtask

  initial begin
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    repeat (3) begin @(posedge clk); model_edge(); end
    @(negedge clk);
    rst = 0;
    check("R1");  // reset state: bus not driven

    // fill every word with linear write bursts
    burst_ileave = 0;
    for (int a = 0; a < DEPTH; a++) drive(a % 4 != 0, 1, a, 4'b0000, "R9");
    sel2 = 0; adv_ld = 0; din = {4'($urandom), $urandom}; step("R1");

    // R5 lane mask: lanes 0 and 2 written, then read back
    drive(0, 1, 5, 4'b1010, "R5");
    drive(0, 1, 9, 4'b1111, "R5");   // completes 5, no-lane write to 9
    drive(0, 0, 5, 4'b0000, "R5");
    drive(0, 0, 9, 4'b0000, "R5");

    // R6 and R4: alternating write/read of the same address
    for (int k = 0; k < 6; k++) drive(0, k % 2 == 0, 7, 4'($urandom), "R6");
    for (int k = 0; k < 8; k++) drive(0, k % 2 == 0, 12 + k, 4'b0000, "R4");

    // R9 linear burst from 6: 6,7,4,5 then wrap
    burst_ileave = 0;
    drive(0, 0, 6, 4'b0, "R9");
    for (int k = 0; k < 4; k++) drive(1, 0, 0, 4'b0, "R9");
    // R10 interleaved from 19: 19,18,17,16
    burst_ileave = 1;
    drive(0, 0, 19, 4'b0, "R10");
    for (int k = 0; k < 3; k++) drive(1, 0, 0, 4'b0, "R10");
    // interleaved write burst, then read back
    drive(0, 1, 26, 4'b0, "R10");
    for (int k = 0; k < 3; k++) drive(1, 1, 0, 4'b0, "R10");
    drive(0, 0, 24, 4'b0, "R10");
    burst_ileave = 0;
    for (int k = 0; k < 3; k++) drive(1, 0, 0, 4'b0, "R10");

    // R2: clock enable off holds a read and a pending write
    drive(0, 0, 9, 4'b0, "R2");
    clk_en_n = 1; wr_n = 0; addr = 3; adv_ld = 0;
    repeat (3) begin din = {4'($urandom), $urandom}; step("R2"); end
    drive(0, 1, 3, 4'b0, "R2");
    clk_en_n = 1; repeat (2) begin din = {4'($urandom), $urandom}; step("R2"); end
    drive(0, 0, 3, 4'b0, "R2");

    // R7: asynchronous output enable inside a read cycle
    drive(0, 0, 11, 4'b0, "R7");
    oe_n = 1; #1;
    checks++;
    if (dout_oe !== 1'b0) begin errors++; $display("FAIL R7 dout_oe actual=%b expected=0", dout_oe); end
    oe_n = 0; #1;
    checks++;
    if (dout_oe !== 1'b1) begin errors++; $display("FAIL R7 dout_oe actual=%b expected=1", dout_oe); end

    // R8: write data cycle ignores oe_n
    drive(0, 1, 11, 4'b0, "R8");

    // R11: sleep, and advance after idle
    sleep = 1; adv_ld = 0; wr_n = 1; addr = 4; step("R11");
    adv_ld = 1; step("R11");
    sleep = 0; step("R11");
    drive(0, 0, 4, 4'b0, "R11");
    sleep = 1; adv_ld = 1; step("R11");
    sleep = 0; step("R11");

    // R1: each chip select alone deselects
    for (int k = 0; k < 3; k++) begin
      clk_en_n = 0; adv_ld = 0; wr_n = 1; addr = 2;
      sel1_n = (k == 0); sel2 = (k != 1); sel3_n = (k == 2);
      step("R1");
    end

    // R3: constrained random mix
    for (int n = 0; n < 3000; n++) begin
      clk_en_n = ($urandom % 10) == 0;
      sel1_n = ($urandom % 16) == 0;
      sel2 = ($urandom % 16) != 0;
      sel3_n = ($urandom % 16) == 0;
      sleep = ($urandom % 20) == 0;
      adv_ld = ($urandom % 5) < 2;
      wr_n = $urandom % 2;
      burst_ileave = $urandom % 2;
      oe_n = ($urandom % 10) == 0;
      lane_en_n = 4'($urandom);
      addr = AW'($urandom);
      din = {4'($urandom), $urandom};
      step("R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule